// File: doc/BRIEF.md
# Quadrature Step Counter

This block turns a pair of quadrature encoder channels into a signed position count. Both channels are brought into the system clock domain by flop synchronisers. The decoder then compares each new two-bit channel state with the one before it and turns legal single-bit changes into up or down steps. A two-bit resolution select picks how many steps one quadrature cycle yields: four, two or one. One code of the select is reserved and stops all counting.

Each decoded step moves a binary position register by one, which wraps at its width. Each step also produces a one-clock step strobe and a direction level. The direction level settles one clock before the strobe rises, so an external counter can take both. A separate one-clock cascade strobe marks wrap-around in either direction, so that counters can be chained. An active-low reset clears everything at once and is released in step with the clock.

Top module: `quad_step_counter`

## Requirements
- R1: While rst_ni is low, count_o reads 0 without waiting for a clock edge, and step_pulse_o, dir_up_o and cascade_o read 0. After release, all of them stay at 0 until a step is decoded.
- R2: With res_sel_i = 2'b10 (four steps per cycle), every change of exactly one channel produces one step.
- R3: A step is up (dir_up_o = 1, count + 1) when A leads B, that is along the {A,B} sequence 00, 10, 11, 01, 00. It is down (dir_up_o = 0, count - 1) along the reverse sequence.
- R4: With res_sel_i = 2'b01 (two steps per cycle), only changes of channel A produce a step. Changes of B alone produce none.
- R5: With res_sel_i = 2'b11 (one step per cycle), only a rising edge of A produces a step. The step is up when B is low at that edge and down when B is high.
- R6: With res_sel_i = 2'b00 (reserved), no channel change produces a step, a strobe or a count change.
- R7: A change of both channels between two synchronised samples is rejected and produces no step.
- R8: A channel change appears as a step 4 clocks later. step_pulse_o is high for exactly that clock, and count_o takes its new value on the same edge.
- R9: dir_up_o holds the direction of a step from at least one clock before step_pulse_o rises until the strobe has ended.
- R10: cascade_o pulses for one clock, together with step_pulse_o, on an up step from all-ones to zero and on a down step from zero to all-ones. It stays low on every other step.
- R11: count_o is CNT_W bits wide (32 by default) and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset; asserts asynchronously, releases on the clock |
| chan_a_i | input | 1 | Quadrature channel A, asynchronous |
| chan_b_i | input | 1 | Quadrature channel B, asynchronous |
| res_sel_i | input | 2 | Resolution select: 10 = x4, 01 = x2, 11 = x1, 00 = no counting |
| count_o | output | CNT_W | Position count |
| step_pulse_o | output | 1 | One-clock strobe per decoded step |
| dir_up_o | output | 1 | Direction of the latest step, 1 = up |
| cascade_o | output | 1 | One-clock strobe on counter wrap |

## Verification
The one-clock strobe and direction-lead properties assume that each channel holds its level for at least two clocks between changes. They also assume that res_sel_i changes only while the channels are idle. Real encoders below the clock rate meet this, since faster edges could merge in the synchronisers. The stimulus moves one input pattern at a time and holds it for five clocks. It changes the resolution select only together with a channel change it can already decode. Each run through a resolution ends back at state 00, so the next mode starts from a known previous state.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_X2   = 2'b01,
    RES_X4   = 2'b10,
    RES_X1   = 2'b11
  } res_e;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ab_i,
  input  res_e       res_i,
  output logic       step_o,
  output logic       dir_o
);
  logic [1:0] prev_q;
  logic [1:0] chg;
  logic       step_d, step_q;
  logic       up_d;
  logic       dir_d, dir_q;

  always_comb begin
    chg    = prev_q ^ ab_i;
    up_d   = ab_i[1] ^ prev_q[0];
    step_d = 1'b0;
    unique case (res_i)
      RES_X4: step_d = ^chg;
      RES_X2: step_d = chg[1] & ~chg[0];
      RES_X1: begin
        step_d = chg[1] & ~chg[0] & ab_i[1];
        up_d   = ~ab_i[0];
      end
      default: step_d = 1'b0;
    endcase
    dir_d = step_d ? up_d : dir_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 2'b00;
      step_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      prev_q <= ab_i;
      step_q <= step_d;
      dir_q  <= dir_d;
    end
  end

  assign step_o = step_q;
  assign dir_o  = dir_q;

  assert_illegal_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_i == RES_NONE) |=> !step_o);

  assert_no_double_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg == 2'b11) |=> !step_o);

  assert_x2_a_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_i == RES_X2 && !chg[1]) |=> !step_o);
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             up_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pulse_o,
  output logic             carry_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;
  logic             pulse_q, carry_q;

  always_comb begin
    wrap  = up_i ? (&cnt_q) : ~(|cnt_q);
    cnt_d = cnt_q;
    if (step_i) cnt_d = up_i ? cnt_q + ONE : cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= step_i;
      carry_q <= step_i & wrap;
    end
  end

  assign count_o = cnt_q;
  assign pulse_o = pulse_q;
  assign carry_o = carry_q;

  assert_moves_on_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (count_o != $past(count_o)));

  assert_still_without_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |-> $stable(count_o));

  assert_cascade_with_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> pulse_o);

  assert_wrap_value_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (count_o == '0 || count_o == '1));
endmodule

// File: rtl/quad_step_counter.sv
module quad_step_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_a_i,
  input  logic             chan_b_i,
  input  logic [1:0]       res_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             step_pulse_o,
  output logic             dir_up_o,
  output logic             cascade_o
);
  logic       rst_sync_n;
  logic [1:0] ab_sync;
  logic       step, dir;

  qdec_sync #(.W(1), .STAGES(2)) i_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  qdec_sync #(.W(2), .STAGES(SYNC_STAGES)) i_chan_sync (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .d_i   ({chan_a_i, chan_b_i}),
    .q_o   (ab_sync)
  );

  qdec_step i_step (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .ab_i  (ab_sync),
    .res_i (res_e'(res_sel_i)),
    .step_o(step),
    .dir_o (dir)
  );

  qdec_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .step_i (step),
    .up_i   (dir),
    .count_o(count_o),
    .pulse_o(step_pulse_o),
    .carry_o(cascade_o)
  );

  assign dir_up_o = dir;

  assert_dir_settled_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(step_pulse_o) |-> $stable(dir_up_o));

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && !step_pulse_o && !cascade_o));
endmodule

// File: tb/test_quad_step_counter.sv
`timescale 1ns/1ps
module test_quad_step_counter;
  localparam real PERIOD = 5.0;
  localparam int  NV     = 32;

  // {res_sel[1:0], a, b, pulse, dir, cascade}
  localparam logic [6:0] VEC [NV] = '{
    7'b10_10_1_1_0, 7'b10_11_1_1_0, 7'b10_01_1_1_0, 7'b10_00_1_1_0,
    7'b10_01_1_0_0, 7'b10_11_1_0_0, 7'b10_10_1_0_0, 7'b10_00_1_0_0,
    7'b10_11_0_0_0, 7'b10_00_0_0_0,
    7'b01_10_1_1_0, 7'b01_11_0_0_0, 7'b01_01_1_1_0, 7'b01_00_0_0_0,
    7'b01_01_0_0_0, 7'b01_11_1_0_0, 7'b01_10_0_0_0, 7'b01_00_1_0_0,
    7'b11_10_1_1_0, 7'b11_11_0_0_0, 7'b11_01_0_0_0, 7'b11_00_0_0_0,
    7'b11_01_0_0_0, 7'b11_11_1_0_0, 7'b11_10_0_0_0, 7'b11_00_0_0_0,
    7'b00_10_0_0_0, 7'b00_11_0_0_0, 7'b00_01_0_0_0, 7'b00_00_0_0_0,
    7'b10_01_1_0_1, 7'b10_00_1_1_1
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        chan_a_i, chan_b_i;
  logic [1:0]  res_sel_i;
  logic [31:0] count_o;
  logic        step_pulse_o, dir_up_o, cascade_o;

  int          n_checks = 0;
  int          n_errors = 0;
  logic        done = 1'b0;
  logic [31:0] exp_count;

  always #(PERIOD/2) clk_i = ~clk_i;

  quad_step_counter i_quad_step_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .chan_a_i(chan_a_i), .chan_b_i(chan_b_i),
    .res_sel_i(res_sel_i), .count_o(count_o), .step_pulse_o(step_pulse_o),
    .dir_up_o(dir_up_o), .cascade_o(cascade_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int idx, input logic [1:0] res, input logic casc);
    if (casc) return "R10";
    if (idx == 8 || idx == 9) return "R7";
    case (res)
      2'b10:   return "R2";
      2'b01:   return "R4";
      2'b11:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // apply at a falling edge, observe after four rising edges
  task automatic apply(input logic [1:0] res, input logic [1:0] ab);
    res_sel_i = res;
    chan_a_i  = ab[1];
    chan_b_i  = ab[0];
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; chan_a_i = 1'b0; chan_b_i = 1'b0; res_sel_i = 2'b10;
    exp_count = '0;
    repeat (3) @(negedge clk_i);
    check("R1 count in reset", count_o, 32'd0);
    check("R1 strobes in reset", {29'd0, step_pulse_o, dir_up_o, cascade_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R1 count after release", count_o, 32'd0);
    check("R1 strobes after release", {29'd0, step_pulse_o, dir_up_o, cascade_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [6:0] v;
      string t;
      v = VEC[i];
      t = tag_of(i, v[6:5], v[0]);
      apply(v[6:5], v[4:3]);
      if (v[2]) exp_count = v[1] ? exp_count + 32'd1 : exp_count - 32'd1;
      check({t, " step strobe"}, {31'd0, step_pulse_o}, {31'd0, v[2]});
      check({t, " count"}, count_o, exp_count);
      check("R10 cascade", {31'd0, cascade_o}, {31'd0, v[0]});
      if (v[2]) check("R3 direction", {31'd0, dir_up_o}, {31'd0, v[1]});
      @(negedge clk_i);
      check("R8 strobe one clock", {31'd0, step_pulse_o}, 32'd0);
      if (i == 30) check("R11 wrap to all ones", count_o, 32'hFFFF_FFFF);
    end

    // R9: direction settles before the strobe rises
    res_sel_i = 2'b10; chan_a_i = 1'b1; chan_b_i = 1'b0;   // up step
    repeat (5) @(negedge clk_i);
    chan_a_i = 1'b0;                                         // 10 -> 00 is down
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R9 dir before strobe", {31'd0, dir_up_o}, 32'd0);
    check("R9 strobe not yet", {31'd0, step_pulse_o}, 32'd0);
    @(negedge clk_i);
    check("R9 strobe with dir held", {30'd0, step_pulse_o, dir_up_o}, 32'd2);
    check("R8 latency count", count_o, 32'd0);

    // R1: asynchronous clear mid-run
    for (int k = 0; k < 3; k++) begin
      apply(2'b10, 2'b10); apply(2'b10, 2'b11); apply(2'b10, 2'b01); apply(2'b10, 2'b00);
    end
    check("R2 twelve up steps", count_o, 32'd12);
    #1;
    rst_ni = 1'b0;
    #0.5;
    check("R1 async clear", count_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R1 count stays clear", count_o, 32'd0);

    // R6: long run in reserved mode leaves count untouched
    for (int k = 0; k < 4; k++) begin
      apply(2'b00, 2'b10); apply(2'b00, 2'b11); apply(2'b00, 2'b01); apply(2'b00, 2'b00);
    end
    check("R6 reserved mode count", count_o, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule